// File: doc/BRIEF.md
# Coherent Split-Byte Result Reader

This block lets an 8-bit bus master read a bank of 16-bit result registers that an internal producer rewrites whenever it likes. The master fetches each value as two byte reads. A read of the upper byte also copies the lower byte of the same register into one temporary byte latch. All registers share that latch. The lower-byte read that follows is answered from the latch, not from the live register. The two bytes therefore always belong to the same 16-bit value, even if the producer writes the register between the two reads.

The producer side is a simple write port: a register index, a 16-bit word and a write enable. The master side takes a byte address and a read strobe, and returns registered read data one cycle later. Software is expected to read the upper byte first and the lower byte second. A lower-byte read on its own simply returns whatever the latch last captured.

Top module: `wide_rd_bridge`

## Requirements
- R1: The byte address is the register index times two plus a byte select bit in bit 0. A select of 0 addresses the upper byte (bits 15:8) and a select of 1 addresses the lower byte (bits 7:0). With the default four registers, the addresses run from 0 to 7.
- R2: A strobed upper-byte read puts the addressed register's bits 15:8 on the read data output on the clock edge that samples the strobe. The output is therefore valid one cycle after the strobe.
- R3: On the same edge as an upper-byte read, the addressed register's bits 7:0 are copied into the single temporary latch that all registers share.
- R4: A lower-byte read returns the latch contents as they stood before that edge, not the live lower byte of the register.
- R5: A producer write that lands between an upper-byte read and the following lower-byte read updates the register and leaves the latch unchanged, so the pair returns the old value. The next upper-byte read returns the new value.
- R6: When the producer writes a register on the same edge as an upper-byte read of that register, both the returned upper byte and the latched lower byte come from the value before the write.
- R7: The latch resets to zero. It changes only on an upper-byte read of any register, so a lower-byte read of a different register returns the byte latched by the last upper-byte read.
- R8: The read data output resets to zero and holds its value in every cycle without a read strobe.
- R9: All result registers reset to zero. A producer write changes only the register named by its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_stb_i | input | 1 | Master read strobe, one cycle per access |
| rd_addr_i | input | 3 | Byte address: index times two plus byte select (0 = upper) |
| rd_data_o | output | 8 | Registered read data, valid the cycle after the strobe |
| upd_en_i | input | 1 | Producer write enable |
| upd_idx_i | input | 2 | Producer register index |
| upd_data_i | input | 16 | Producer write data |

## Verification
The bench targets three cases. The first is a producer write between the two byte reads: a design that reads the live lower byte would return a torn value made of the old upper byte and the new lower byte. The second is a write on the same edge as an upper-byte read: a design that forwards the write data would return bytes from the new value where the old one is expected. The third is a lower-byte read of a register other than the one last read high: a design that keeps one latch per register, or that refills the latch on lower-byte reads, returns the wrong byte. Long random traffic is compared every cycle against a behavioural model, which also catches a broken address map and read data that drifts while the strobe is idle.

// File: rtl/wide_rd_pkg.sv
package wide_rd_pkg;

    localparam int BYTE_W = 8;

    // State of the master-side read path
    typedef struct packed {
        logic [BYTE_W-1:0] hold;   // shared temporary latch
        logic [BYTE_W-1:0] data;   // registered read data
    } rd_state_t;

    localparam rd_state_t RD_STATE_RST = '{hold: '0, data: '0};

endpackage

// File: rtl/wide_rd_bank.sv
module wide_rd_bank #(
    parameter int NUM_REGS = 4,
    parameter int WORD_W   = 16,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             upd_en_i,
    input  logic [IDX_W-1:0]                 upd_idx_i,
    input  logic [WORD_W-1:0]                upd_data_i,
    output logic [NUM_REGS-1:0][WORD_W-1:0]  regs_o
);

    logic [NUM_REGS-1:0][WORD_W-1:0] regs_d, regs_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        always_comb begin
            regs_d[g] = regs_q[g];
            if (upd_en_i && (upd_idx_i == IDX_W'(g))) begin
                regs_d[g] = upd_data_i;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                regs_q[g] <= '0;
            end else begin
                regs_q[g] <= regs_d[g];
            end
        end
    end

    assign regs_o = regs_q;

endmodule

// File: rtl/wide_rd_decode.sv
module wide_rd_decode #(
    parameter int NUM_REGS = 4,
    parameter int WORD_W   = 16,
    localparam int BYTE_W  = wide_rd_pkg::BYTE_W,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int ADDR_W  = IDX_W + 1
) (
    input  logic [ADDR_W-1:0]                rd_addr_i,
    input  logic [NUM_REGS-1:0][WORD_W-1:0]  regs_i,
    output logic                             sel_upper_o,
    output logic [BYTE_W-1:0]                hi_byte_o,
    output logic [BYTE_W-1:0]                lo_byte_o
);

    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] word;

    always_comb begin
        idx         = rd_addr_i[ADDR_W-1:1];
        sel_upper_o = ~rd_addr_i[0];
        word        = regs_i[idx];
        hi_byte_o   = word[WORD_W-1 -: BYTE_W];
        lo_byte_o   = word[BYTE_W-1:0];
    end

endmodule

// File: rtl/wide_rd_port.sv
module wide_rd_port
    import wide_rd_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rd_stb_i,
    input  logic              sel_upper_i,
    input  logic [BYTE_W-1:0] hi_byte_i,
    input  logic [BYTE_W-1:0] lo_byte_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic [BYTE_W-1:0] hold_o
);

    rd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_stb_i) begin
            if (sel_upper_i) begin
                st_d.data = hi_byte_i;
                st_d.hold = lo_byte_i;
            end else begin
                st_d.data = st_q.hold;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= RD_STATE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.data;
    assign hold_o    = st_q.hold;

endmodule

// File: rtl/wide_rd_bridge.sv
module wide_rd_bridge #(
    parameter int NUM_REGS = 4,
    parameter int WORD_W   = 16,
    localparam int BYTE_W  = wide_rd_pkg::BYTE_W,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int ADDR_W  = IDX_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rd_stb_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [BYTE_W-1:0] rd_data_o,
    input  logic              upd_en_i,
    input  logic [IDX_W-1:0]  upd_idx_i,
    input  logic [WORD_W-1:0] upd_data_i
);

    logic [NUM_REGS-1:0][WORD_W-1:0] regs_w;
    logic                            sel_upper_w;
    logic [BYTE_W-1:0]               hi_byte_w;
    logic [BYTE_W-1:0]               lo_byte_w;
    logic [BYTE_W-1:0]               hold_w;

    wide_rd_bank #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) bank_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .upd_en_i   (upd_en_i),
        .upd_idx_i  (upd_idx_i),
        .upd_data_i (upd_data_i),
        .regs_o     (regs_w)
    );

    wide_rd_decode #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) dec_i (
        .rd_addr_i   (rd_addr_i),
        .regs_i      (regs_w),
        .sel_upper_o (sel_upper_w),
        .hi_byte_o   (hi_byte_w),
        .lo_byte_o   (lo_byte_w)
    );

    wide_rd_port port_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .rd_stb_i    (rd_stb_i),
        .sel_upper_i (sel_upper_w),
        .hi_byte_i   (hi_byte_w),
        .lo_byte_i   (lo_byte_w),
        .rd_data_o   (rd_data_o),
        .hold_o      (hold_w)
    );

endmodule

// File: rtl/wide_rd_bridge_chk.sv
module wide_rd_bridge_chk #(
    parameter int ADDR_W = 3,
    parameter int BYTE_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              rd_stb_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic [BYTE_W-1:0] rd_data_i,
    input logic              upd_en_i,
    input logic [BYTE_W-1:0] hold_i
);

    // R4: lower-byte read returns the latch as it was before the edge
    a_r4_low_from_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_stb_i && rd_addr_i[0]) |=> (rd_data_i == $past(hold_i)));

    // R7: latch moves only on an upper-byte read
    a_r7_latch_only_on_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rd_stb_i && !rd_addr_i[0]) |=> $stable(hold_i));

    // R5: producer writes alone never disturb the latch
    a_r5_write_keeps_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_en_i && !rd_stb_i) |=> $stable(hold_i));

    // R8: read data holds while no strobe
    a_r8_data_holds_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_stb_i |=> $stable(rd_data_i));

    // R7/R8: reset values
    a_r7_reset_zero: assert property (@(posedge clk_i)
        !rst_ni |=> (hold_i == '0 || rst_ni));

endmodule

bind wide_rd_bridge wide_rd_bridge_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_stb_i  (rd_stb_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_i (rd_data_o),
    .upd_en_i  (upd_en_i),
    .hold_i    (hold_w)
);

// File: tb/wide_rd_bridge_tb_top.sv
module wide_rd_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_stb = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        upd_en = 1'b0;
    logic [1:0]  upd_idx = '0;
    logic [15:0] upd_data = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural reference
    int m_regs[4];
    int m_hold;
    int m_data;

    always #5 clk = ~clk;

    wide_rd_bridge dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .rd_stb_i   (rd_stb),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .upd_en_i   (upd_en),
        .upd_idx_i  (upd_idx),
        .upd_data_i (upd_data)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input bit stb, input int addr, input bit en,
                        input int idx, input int data, input string req);
        rd_stb   = stb;
        rd_addr  = 3'(addr);
        upd_en   = en;
        upd_idx  = 2'(idx);
        upd_data = 16'(data);
        @(posedge clk);
        if (stb) begin
            if ((addr % 2) == 0) begin
                m_data = m_regs[addr / 2] / 256;
                m_hold = m_regs[addr / 2] % 256;
            end else begin
                m_data = m_hold;
            end
        end
        if (en) m_regs[idx] = data;
        @(negedge clk);
        check_eq(req, int'(rd_data), m_data);
    endtask

    task automatic rd(input int addr, input int exp, input string req);
        step(1'b1, addr, 1'b0, 0, 0, req);
        check_eq(req, int'(rd_data), exp);
    endtask

    task automatic wr(input int idx, input int data);
        step(1'b0, 0, 1'b1, idx, data, "R9");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m_regs[i] = 0;
        m_hold = 0;
        m_data = 0;
        repeat (3) @(negedge clk);
        check_eq("R8 reset data", int'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: lone lower read after reset gives the zero latch
        rd(5, 8'h00, "R7 reset latch");
        // R9: reset registers read zero
        rd(6, 8'h00, "R9 reset reg");

        // R2/R3/R4 basic pair
        wr(0, 16'hAA40);
        rd(0, 8'hAA, "R2 upper");
        rd(1, 8'h40, "R4 lower");

        // R1: distinct value in every register, all bytes
        wr(1, 16'h1122); wr(2, 16'h3344); wr(3, 16'h5566);
        rd(2, 8'h11, "R1 reg1 hi"); rd(3, 8'h22, "R1 reg1 lo");
        rd(4, 8'h33, "R1 reg2 hi"); rd(5, 8'h44, "R1 reg2 lo");
        rd(6, 8'h55, "R1 reg3 hi"); rd(7, 8'h66, "R1 reg3 lo");

        // R5: write between the pair
        wr(1, 16'h1234);
        rd(2, 8'h12, "R5 hi");
        wr(1, 16'h5678);
        rd(3, 8'h34, "R5 lower keeps old");
        rd(2, 8'h56, "R5 new hi");
        rd(3, 8'h78, "R5 new lo");

        // R6: write on the same edge as the upper read
        wr(3, 16'h9ABC);
        step(1'b1, 6, 1'b1, 3, 16'hDEF0, "R6 collide");
        check_eq("R6 old hi", int'(rd_data), 8'h9A);
        rd(7, 8'hBC, "R6 old lo");
        rd(6, 8'hDE, "R6 new hi");

        // R7: latch shared across registers
        rd(0, 8'hAA, "R7 hi reg0");
        rd(5, 8'h40, "R7 lower of reg2 gives reg0 latch");
        rd(3, 8'h40, "R7 latch persists");

        // R8: idle cycles keep data
        step(1'b0, 0, 1'b0, 0, 0, "R8 idle");
        check_eq("R8 idle hold", int'(rd_data), 8'h40);
        step(1'b0, 4, 1'b1, 0, 16'h0F0F, "R8 idle write");
        check_eq("R8 idle write hold", int'(rd_data), 8'h40);

        // R9: write to reg0 left reg2 alone
        rd(4, 8'h33, "R9 other reg intact");
        rd(0, 8'h0F, "R9 written reg");

        // random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            step(1'($urandom_range(0, 1)), $urandom_range(0, 7),
                 1'($urandom_range(0, 1)), $urandom_range(0, 3),
                 $urandom_range(0, 65535), "R1-model");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule